// File: doc/BRIEF.md
# MII Receive Nibble-to-Byte Aligner

This block sits on the MAC side of a 4-bit media-independent receive path. On every rising edge of the receive clock it samples the nibble bus, the data-valid line and the error line. It looks for the start-of-frame delimiter nibble, and from then on it packs nibble pairs into bytes. The block does not need a complete preamble. The PHY may raise data-valid late and hide most of the preamble, so a single preamble nibble ahead of the delimiter is enough to lock.

Bytes leave as a stream with a one-cycle valid strobe. The first byte of a frame carries a start marker. The end of a frame is a separate one-cycle pulse with two flags: a decode-error flag and an alignment-error flag.

Outside a frame, the PHY can signal through the error line with data-valid low. The block decodes two such codes into level indications: link partner in low-power idle, and false carrier. The asynchronous carrier-sense and collision lines are synchronized, and the block reports the pairing that no working PHY produces, which marks the PHY as absent. CRC checking, address filtering and buffering are left to later stages.

Top module: `mii_rx_aligner`

## Requirements
- R1: While reset is low and on the first cycle after it, byteValid, frameStart, frameEnd, endDecodeErr, endAlignErr, lowPowerIdle, falseCarrier and phyMissing are all 0.
- R2: Byte alignment is fixed by the first nibble 4'hD that follows one or more 4'h5 nibbles, all with rxValid high. Nibbles before it produce no output, and a 4'hD that has no 4'h5 directly before it does not lock.
- R3: A preamble of a single 4'h5 nibble before the 4'hD is enough to lock.
- R4: The nibble received first after lock forms bits [3:0] of byteData, and the nibble after it forms bits [7:4]. byteValid pulses in the cycle after the second nibble is sampled.
- R5: frameStart is 1 together with the first byteValid of a frame and is 0 on every later byte.
- R6: After lock, the first edge that samples rxValid low produces a one-cycle frameEnd pulse in the following cycle. When an even number of nibbles followed the delimiter, endAlignErr is 0.
- R7: When an odd number of nibbles followed the delimiter, the leftover nibble produces no byte, and frameEnd comes with endAlignErr = 1.
- R8: If rxErr is high while rxValid is high on any nibble after the delimiter, endDecodeErr is 1 on that frame's frameEnd pulse. Otherwise it is 0.
- R9: lowPowerIdle is 1 in the cycle after a sample with rxValid = 0, rxErr = 1 and rxData = 4'h1, and 0 after any other sample.
- R10: falseCarrier is 1 in the cycle after a sample with rxValid = 0, rxErr = 1 and rxData = 4'hE, and 0 after any other sample. The same code values with rxValid high set neither indication.
- R11: phyMissing is 1 when the synchronized collision line is high and the synchronized carrier line is low, three clock edges after the inputs settle. It returns to 0 the same way.
- R12: If rxValid falls before lock, no byteValid and no frameEnd is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 4 | Receive nibble, bit 0 earliest |
| rxValid | input | 1 | Receive data valid |
| rxErr | input | 1 | Receive error / out-of-frame signalling qualifier |
| crsAsync | input | 1 | Carrier sense, asynchronous |
| colAsync | input | 1 | Collision detect, asynchronous |
| byteData | output | 8 | Assembled byte |
| byteValid | output | 1 | byteData valid strobe |
| frameStart | output | 1 | First byte of a frame |
| frameEnd | output | 1 | One-cycle end-of-frame pulse |
| endDecodeErr | output | 1 | Frame contained a decode error (with frameEnd) |
| endAlignErr | output | 1 | Frame ended on an odd nibble (with frameEnd) |
| lowPowerIdle | output | 1 | Link partner low-power idle indication |
| falseCarrier | output | 1 | False carrier indication |
| phyMissing | output | 1 | Collision-without-carrier, PHY absent |

## Verification
The hardest case to reach from the ports is a frame whose alignment is ambiguous. Such a frame has a delimiter value before any preamble, a preamble cut to one nibble, or a trailing half byte. If the aligner locks on the wrong nibble, every later byte comes out swapped. The driver prefixes some frames with a stray 4'hD and other junk nibbles, shortens the preamble to one nibble, and ends frames with an odd tail. Each case pushes its exact expected byte sequence and end flags into the scoreboard queue, so a one-nibble slip shows up as a data mismatch.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  localparam logic [NIB_W-1:0] PRE_NIB  = 4'h5;
  localparam logic [NIB_W-1:0] SFD_NIB  = 4'hD;
  localparam logic [NIB_W-1:0] LPI_CODE = 4'h1;
  localparam logic [NIB_W-1:0] FC_CODE  = 4'hE;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } rxState_t;

  typedef struct packed {
    logic startFrame;
    logic takeLow;
    logic takeHigh;
    logic closeFrame;
    logic oddClose;
  } rxStrobe_t;
endpackage

// File: rtl/mii_rx_ctrl.sv
module mii_rx_ctrl
  import mii_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] rxData,
  input  logic             rxValid,
  output rxStrobe_t        strobe
);
  rxState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_HUNT: begin
        if (rxValid && rxData == PRE_NIB) nextState = ST_PRE;
      end
      ST_PRE: begin
        if (!rxValid) begin
          nextState = ST_HUNT;
        end else if (rxData == SFD_NIB) begin
          nextState         = ST_LOW;
          strobe.startFrame = 1'b1;
        end else if (rxData != PRE_NIB) begin
          nextState = ST_HUNT;
        end
      end
      ST_LOW: begin
        if (rxValid) begin
          nextState      = ST_HIGH;
          strobe.takeLow = 1'b1;
        end else begin
          nextState         = ST_HUNT;
          strobe.closeFrame = 1'b1;
        end
      end
      ST_HIGH: begin
        if (rxValid) begin
          nextState       = ST_LOW;
          strobe.takeHigh = 1'b1;
        end else begin
          nextState         = ST_HUNT;
          strobe.closeFrame = 1'b1;
          strobe.oddClose   = 1'b1;
        end
      end
      default: nextState = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= nextState;
  end
endmodule

// File: rtl/mii_rx_datapath.sv
module mii_rx_datapath
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  rxData,
  input  logic              rxErr,
  input  rxStrobe_t         strobe,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              frameStart,
  output logic              frameEnd,
  output logic              endDecodeErr,
  output logic              endAlignErr
);
  logic [NIB_W-1:0] lowNib;
  logic             errAcc;
  logic             firstPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowNib       <= '0;
      errAcc       <= 1'b0;
      firstPend    <= 1'b0;
      byteData     <= '0;
      byteValid    <= 1'b0;
      frameStart   <= 1'b0;
      frameEnd     <= 1'b0;
      endDecodeErr <= 1'b0;
      endAlignErr  <= 1'b0;
    end else begin
      byteValid    <= 1'b0;
      frameStart   <= 1'b0;
      frameEnd     <= 1'b0;
      endDecodeErr <= 1'b0;
      endAlignErr  <= 1'b0;
      if (strobe.startFrame) begin
        errAcc    <= 1'b0;
        firstPend <= 1'b1;
      end
      if (strobe.takeLow) begin
        lowNib <= rxData;
        errAcc <= errAcc | rxErr;
      end
      if (strobe.takeHigh) begin
        byteData   <= {rxData, lowNib};
        byteValid  <= 1'b1;
        frameStart <= firstPend;
        firstPend  <= 1'b0;
        errAcc     <= errAcc | rxErr;
      end
      if (strobe.closeFrame) begin
        frameEnd     <= 1'b1;
        endDecodeErr <= errAcc;
        endAlignErr  <= strobe.oddClose;
        firstPend    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mii_rx_sideband.sv
module mii_rx_sideband
  import mii_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] rxData,
  input  logic             rxValid,
  input  logic             rxErr,
  input  logic             crsAsync,
  input  logic             colAsync,
  output logic             lowPowerIdle,
  output logic             falseCarrier,
  output logic             phyMissing
);
  logic [SYNC_STAGES-1:0] crsChain;
  logic [SYNC_STAGES-1:0] colChain;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) begin
            crsChain[0] <= 1'b0;
            colChain[0] <= 1'b0;
          end else begin
            crsChain[0] <= crsAsync;
            colChain[0] <= colAsync;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) begin
            crsChain[g] <= 1'b0;
            colChain[g] <= 1'b0;
          end else begin
            crsChain[g] <= crsChain[g-1];
            colChain[g] <= colChain[g-1];
          end
        end
      end
    end
  endgenerate

  logic oobCode;
  assign oobCode = !rxValid && rxErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowPowerIdle <= 1'b0;
      falseCarrier <= 1'b0;
      phyMissing   <= 1'b0;
    end else begin
      lowPowerIdle <= oobCode && (rxData == LPI_CODE);
      falseCarrier <= oobCode && (rxData == FC_CODE);
      phyMissing   <= colChain[SYNC_STAGES-1] && !crsChain[SYNC_STAGES-1];
    end
  end
endmodule

// File: rtl/mii_rx_aligner.sv
module mii_rx_aligner
  import mii_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  rxData,
  input  logic              rxValid,
  input  logic              rxErr,
  input  logic              crsAsync,
  input  logic              colAsync,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              frameStart,
  output logic              frameEnd,
  output logic              endDecodeErr,
  output logic              endAlignErr,
  output logic              lowPowerIdle,
  output logic              falseCarrier,
  output logic              phyMissing
);
  rxStrobe_t strobe;

  mii_rx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxData  (rxData),
    .rxValid (rxValid),
    .strobe  (strobe)
  );

  mii_rx_datapath u_data (
    .clk          (clk),
    .rstN         (rstN),
    .rxData       (rxData),
    .rxErr        (rxErr),
    .strobe       (strobe),
    .byteData     (byteData),
    .byteValid    (byteValid),
    .frameStart   (frameStart),
    .frameEnd     (frameEnd),
    .endDecodeErr (endDecodeErr),
    .endAlignErr  (endAlignErr)
  );

  mii_rx_sideband #(.SYNC_STAGES(SYNC_STAGES)) u_side (
    .clk          (clk),
    .rstN         (rstN),
    .rxData       (rxData),
    .rxValid      (rxValid),
    .rxErr        (rxErr),
    .crsAsync     (crsAsync),
    .colAsync     (colAsync),
    .lowPowerIdle (lowPowerIdle),
    .falseCarrier (falseCarrier),
    .phyMissing   (phyMissing)
  );
endmodule

// File: rtl/mii_rx_aligner_checker.sv
module mii_rx_aligner_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] rxData,
  input logic       rxValid,
  input logic       rxErr,
  input logic       byteValid,
  input logic       frameStart,
  input logic       frameEnd,
  input logic       endDecodeErr,
  input logic       endAlignErr,
  input logic       lowPowerIdle,
  input logic       falseCarrier
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!byteValid && !frameEnd && !lowPowerIdle && !falseCarrier));

  a_r4_byte_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(rxValid));

  a_r5_start_with_byte: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> byteValid);

  a_r6_end_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> ($past(!rxValid) && !byteValid));

  a_r7_align_only_at_end: assert property (@(posedge clk) disable iff (!rstN)
    endAlignErr |-> frameEnd);

  a_r8_decode_only_at_end: assert property (@(posedge clk) disable iff (!rstN)
    endDecodeErr |-> frameEnd);

  a_r9_lpi_code: assert property (@(posedge clk) disable iff (!rstN)
    lowPowerIdle |-> $past(!rxValid && rxErr && rxData == 4'h1));

  a_r10_fc_code: assert property (@(posedge clk) disable iff (!rstN)
    falseCarrier |-> $past(!rxValid && rxErr && rxData == 4'hE));
endmodule

bind mii_rx_aligner mii_rx_aligner_checker u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .rxData       (rxData),
  .rxValid      (rxValid),
  .rxErr        (rxErr),
  .byteValid    (byteValid),
  .frameStart   (frameStart),
  .frameEnd     (frameEnd),
  .endDecodeErr (endDecodeErr),
  .endAlignErr  (endAlignErr),
  .lowPowerIdle (lowPowerIdle),
  .falseCarrier (falseCarrier)
);

// File: tb/mii_rx_aligner_tb.sv
`timescale 1ns/1ps
module mii_rx_aligner_tb;
  typedef struct packed {
    logic [7:0] data;
    logic       sof;
    logic       eop;
    logic       derr;
    logic       aerr;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] rxData = '0;
  logic       rxValid = 1'b0;
  logic       rxErr = 1'b0;
  logic       crsAsync = 1'b0;
  logic       colAsync = 1'b0;
  logic [7:0] byteData;
  logic       byteValid, frameStart, frameEnd, endDecodeErr, endAlignErr;
  logic       lowPowerIdle, falseCarrier, phyMissing;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t expQ[$];

  always #2 clk = ~clk;

  mii_rx_aligner u_dut (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxErr(rxErr),
    .crsAsync(crsAsync), .colAsync(colAsync), .byteData(byteData),
    .byteValid(byteValid), .frameStart(frameStart), .frameEnd(frameEnd),
    .endDecodeErr(endDecodeErr), .endAlignErr(endAlignErr),
    .lowPowerIdle(lowPowerIdle), .falseCarrier(falseCarrier), .phyMissing(phyMissing)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard for the byte stream and end pulses
  always @(negedge clk) begin
    if (rstN && (byteValid || frameEnd)) begin
      item_t got;
      got = '{data: (byteValid ? byteData : 8'h00), sof: frameStart, eop: frameEnd,
              derr: endDecodeErr, aerr: endAlignErr};
      if (expQ.size() == 0) begin
        check(1'b0, "R2/R12 unexpected output", int'(got), 0);
      end else begin
        item_t exp;
        exp = expQ.pop_front();
        check(got == exp, "R4/R5/R6/R7/R8 stream item", int'(got), int'(exp));
      end
    end
  end

  task automatic drive(input logic [3:0] n, input logic dv, input logic er);
    @(negedge clk);
    rxData = n; rxValid = dv; rxErr = er;
  endtask

  // Driver: pushes expected items, then drives the nibbles
  task automatic sendFrame(input int pre, input int nBytes, input int seed,
                           input bit oddTail, input int errNib, input bit junk);
    int k;
    int total;
    total = 2 * nBytes + (oddTail ? 1 : 0);
    for (int i = 0; i < nBytes; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 37) & 8'hFF);
      expQ.push_back('{data: b, sof: (i == 0), eop: 1'b0, derr: 1'b0, aerr: 1'b0});
    end
    expQ.push_back('{data: 8'h00, sof: 1'b0, eop: 1'b1,
                     derr: (errNib >= 0 && errNib < total), aerr: oddTail});
    if (junk) begin
      drive(4'hD, 1'b1, 1'b0);
      drive(4'hA, 1'b1, 1'b0);
      drive(4'hD, 1'b1, 1'b0);
    end
    for (int i = 0; i < pre; i++) drive(4'h5, 1'b1, 1'b0);
    drive(4'hD, 1'b1, 1'b0);
    k = 0;
    for (int i = 0; i < nBytes; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 37) & 8'hFF);
      drive(b[3:0], 1'b1, k == errNib); k++;
      drive(b[7:4], 1'b1, k == errNib); k++;
    end
    if (oddTail) drive(4'h7, 1'b1, k == errNib);
    drive(4'h0, 1'b0, 1'b0);
    drive(4'h0, 1'b0, 1'b0);
    drive(4'h0, 1'b0, 1'b0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!byteValid && !frameEnd && !frameStart && !lowPowerIdle && !falseCarrier && !phyMissing,
          "R1 reset outputs", {byteValid, frameEnd, lowPowerIdle, falseCarrier, phyMissing}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!byteValid && !frameEnd && !phyMissing, "R1 first cycle after reset",
          {byteValid, frameEnd, phyMissing}, 0);

    // R2 R4 R5 R6: full preamble, even length
    sendFrame(7, 6, 8'h21, 1'b0, -1, 1'b0);
    // R3: single preamble nibble
    sendFrame(1, 4, 8'hC3, 1'b0, -1, 1'b0);
    // R2: stray delimiter and junk before preamble
    sendFrame(2, 3, 8'h5A, 1'b0, -1, 1'b1);
    // R7: odd tail
    sendFrame(3, 2, 8'h90, 1'b1, -1, 1'b0);
    // R8: decode error mid frame
    sendFrame(4, 5, 8'h11, 1'b0, 5, 1'b0);
    // R8 and R7: error on odd tail nibble
    sendFrame(2, 1, 8'hEE, 1'b1, 2, 1'b0);
    // R6: empty frame right after delimiter
    sendFrame(2, 0, 8'h00, 1'b0, -1, 1'b0);

    // R12: valid drops before lock, no output expected
    drive(4'h5, 1'b1, 1'b0);
    drive(4'h5, 1'b1, 1'b0);
    drive(4'h3, 1'b1, 1'b0);
    drive(4'hD, 1'b1, 1'b0);
    drive(4'h0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R12 nothing pending", expQ.size(), 0);

    // R9: low-power idle code
    drive(4'h1, 1'b0, 1'b1);
    @(negedge clk);
    check(lowPowerIdle && !falseCarrier, "R9 lpi set", {lowPowerIdle, falseCarrier}, 2);
    // R10: false carrier code
    drive(4'hE, 1'b0, 1'b1);
    @(negedge clk);
    check(falseCarrier && !lowPowerIdle, "R10 fc set", {lowPowerIdle, falseCarrier}, 1);
    // R9: other code clears both
    drive(4'h2, 1'b0, 1'b1);
    @(negedge clk);
    check(!falseCarrier && !lowPowerIdle, "R9 other code clears", {lowPowerIdle, falseCarrier}, 0);
    // R10: code with rxValid high sets neither
    drive(4'h1, 1'b1, 1'b1);
    @(negedge clk);
    check(!falseCarrier && !lowPowerIdle, "R10 in-frame code ignored", {lowPowerIdle, falseCarrier}, 0);
    drive(4'hE, 1'b1, 1'b1);
    @(negedge clk);
    check(!falseCarrier && !lowPowerIdle, "R10 in-frame fc ignored", {lowPowerIdle, falseCarrier}, 0);
    drive(4'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0 && !byteValid, "R12 in-frame codes no output", expQ.size(), 0);

    // R11: phy missing after synchronizer
    @(negedge clk);
    colAsync = 1'b1; crsAsync = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!phyMissing, "R11 not yet after two edges", phyMissing, 0);
    @(posedge clk);
    @(negedge clk);
    check(phyMissing, "R11 missing after three edges", phyMissing, 1);
    crsAsync = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!phyMissing, "R11 carrier with collision clears", phyMissing, 0);
    colAsync = 1'b0; crsAsync = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!phyMissing, "R11 idle lines", phyMissing, 0);

    // R2: after sideband traffic a normal frame still aligns
    sendFrame(5, 3, 8'h47, 1'b0, -1, 1'b0);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R6 scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    finishRun();
  end
endmodule